// File: doc/BRIEF.md
# Word FIFO Status and Interrupt Unit

This unit sits between a host register port and the data path of a serial flash controller. It holds a transmit FIFO and a receive FIFO of 32-bit words. The host pushes transmit words and pops receive words through one data register. The serial sequencer drains the transmit side and fills the receive side through plain strobe inputs. A status word reports the fill state of both FIFOs. Two programmable thresholds turn the fill levels into interrupt sources.

Eight raw interrupt sources latch into a sticky register. Threshold crossings, FIFO misuse by the host, and four external events from the sequencer and the DMA engine all set sources. A mask register decides which latched sources reach the single interrupt output. Software removes latched sources through a write-one-to-clear register.

Top module: `fifo_irq_unit`

## Requirements
- R1: After reset, the mask register (offset 2) reads 0xFF, the latched source register (offset 4) reads 0, both FIFOs are empty and both thresholds are 0.
- R2: A host write to the data register (offset 0) appends the word to the transmit FIFO when it is not full. `tx_data` shows the oldest word while `tx_avail` is high. A `tx_pop` pulse removes that word, and a pop on an empty FIFO does nothing.
- R3: A host read of the data register returns the oldest receive word and removes it in the same cycle. A `rx_push` pulse stores `rx_data` when the receive FIFO is not full and is dropped otherwise.
- R4: The status word (offset 6) holds transmit full at bit 0, transmit empty at bit 1, receive empty at bit 2, receive full at bit 3, free transmit words at [12:8] and stored receive words at [20:16]. All other bits read 0.
- R5: The threshold register (offset 1) holds the transmit threshold in [4:0] and the receive threshold in [12:8]. Source 0 latches in any cycle whose starting receive level is at least the receive threshold. Source 3 latches in any cycle whose starting free transmit space is at least the transmit threshold.
- R6: A data write while the transmit FIFO is full discards the word, leaves the level unchanged and latches source 2.
- R7: A data read while the receive FIFO is empty returns 0 and latches source 1.
- R8: The inputs `evt_done`, `evt_bus_err`, `evt_proto_err` and `evt_dma_done` latch sources 4, 5, 6 and 7.
- R9: Sources latch whether they are masked or not. A mask bit of 1 blocks its source. Offset 5 reads latched AND NOT mask, and `irq` is high when that value is non-zero.
- R10: Writing the clear register (offset 3) clears each latched bit written as 1. Bits written as 0 are unaffected. A source event in the same cycle as its clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (pops the receive FIFO at offset 0) |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data, combinational from the address |
| tx_pop | input | 1 | Sequencer takes the oldest transmit word |
| tx_data | output | 32 | Oldest transmit word |
| tx_avail | output | 1 | Transmit FIFO holds at least one word |
| rx_push | input | 1 | Sequencer stores a receive word |
| rx_data | input | 32 | Receive word from the sequencer |
| evt_done | input | 1 | Transfer finished event |
| evt_bus_err | input | 1 | Bus error event |
| evt_proto_err | input | 1 | Non-serial protocol error event |
| evt_dma_done | input | 1 | DMA completion event |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a clear that lands in the same cycle as a new event on the same source bit. The threshold sources re-latch every cycle their condition holds, which also hides whether a clear worked. The directed part of the stimulus first raises both thresholds out of reach. It then drives `evt_done` together with a clear of bit 4, and separately clears with zero bits, checking the latched register on the next read. A random phase then mixes host accesses, pops, pushes and events, so the FIFOs pass through full and empty many times with the thresholds changing.

// File: rtl/fifo_irq_pkg.sv
// Shared constants for the word FIFO status and interrupt unit.
// Assumes a register port addressed by word offsets of three bits.
package fifo_irq_pkg;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int NUM_SRC  = 8;
    localparam int THR_W    = 5;
    localparam int FIELD_W  = 5;

    // register word offsets
    localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_THR   = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_MASK  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 3'd6;

    // interrupt source bit positions
    localparam int SRC_RX_THR   = 0;
    localparam int SRC_RX_UFLOW = 1;
    localparam int SRC_TX_OFLOW = 2;
    localparam int SRC_TX_THR   = 3;
    localparam int SRC_DONE     = 4;
    localparam int SRC_BUS_ERR  = 5;
    localparam int SRC_PROTO    = 6;
    localparam int SRC_DMA      = 7;
endpackage

// File: rtl/fifo_word_buf.sv
// Synchronous word FIFO with a fill counter.
// Assumes DEPTH is a power of two. A push when full and a pop when
// empty are ignored. The head word is presented combinationally.
module fifo_word_buf #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    assign full    = (count == LW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    // storage write on an accepted push
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // pointer advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
        end
    end

    // fill counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({do_push, do_pop})
                2'b10:   count <= count + LW'(1);
                2'b01:   count <= count - LW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/irq_collect.sv
// Sticky interrupt source register with mask and write-one-to-clear.
// Sources latch regardless of the mask. A set in the same cycle as a
// clear wins. The mask resets to all ones, so every source is blocked.
module irq_collect #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic         clr_we,
    input  logic [N-1:0] clr_i,
    input  logic         mask_we,
    input  logic [N-1:0] mask_i,
    output logic [N-1:0] raw_o,
    output logic [N-1:0] mask_o,
    output logic [N-1:0] pend_o,
    output logic         irq_o
);
    logic [N-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_i : '0;

    // latched sources, set has priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) raw_o <= '0;
        else        raw_o <= (raw_o & ~clr_eff) | set_i;
    end

    // mask register, 1 blocks the source
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_o <= '1;
        else if (mask_we) mask_o <= mask_i;
    end

    assign pend_o = raw_o & ~mask_o;
    assign irq_o  = |pend_o;
endmodule

// File: rtl/fifo_irq_unit.sv
// Top of the word FIFO status and interrupt unit.
// It decodes the host register port, instantiates both FIFOs and the
// interrupt collector, and builds the threshold and misuse events.
// Assumes at most one of reg_wr and reg_rd per cycle. DEPTH must fit
// in the five-bit level fields.
module fifo_irq_unit
    import fifo_irq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              tx_pop,
    output logic [31:0]       tx_data,
    output logic              tx_avail,
    input  logic              rx_push,
    input  logic [31:0]       rx_data,
    input  logic              evt_done,
    input  logic              evt_bus_err,
    input  logic              evt_proto_err,
    input  logic              evt_dma_done,
    output logic              irq
);
    localparam int LW = $clog2(DEPTH+1);

    logic [LW-1:0]      tx_cnt, rx_cnt, tx_free;
    logic               tx_full, tx_empty, rx_full, rx_empty;
    logic [WORD_W-1:0]  rx_head;
    logic [THR_W-1:0]   tx_thr_q, rx_thr_q;
    logic [NUM_SRC-1:0] src_set, raw_q, mask_q, pend_q;
    logic               data_wr, data_rd;
    logic               thr_we, mask_we, clr_we;
    logic [WORD_W-1:0]  stat_word;

    assign data_wr = reg_wr && (reg_addr == OFS_DATA);
    assign data_rd = reg_rd && (reg_addr == OFS_DATA);
    assign thr_we  = reg_wr && (reg_addr == OFS_THR);
    assign mask_we = reg_wr && (reg_addr == OFS_MASK);
    assign clr_we  = reg_wr && (reg_addr == OFS_CLR);

    fifo_word_buf #(.W(WORD_W), .DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n),
        .push(data_wr), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    fifo_word_buf #(.W(WORD_W), .DEPTH(DEPTH)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .push(rx_push), .wdata(rx_data),
        .pop(data_rd), .rdata(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    assign tx_avail = !tx_empty;
    assign tx_free  = LW'(DEPTH) - tx_cnt;

    // threshold register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr_q <= '0;
            rx_thr_q <= '0;
        end else if (thr_we) begin
            tx_thr_q <= reg_wdata[THR_W-1:0];
            rx_thr_q <= reg_wdata[8 +: THR_W];
        end
    end

    // source events for the current cycle
    always_comb begin
        src_set               = '0;
        src_set[SRC_RX_THR]   = 32'(rx_cnt) >= 32'(rx_thr_q);
        src_set[SRC_RX_UFLOW] = data_rd && rx_empty;
        src_set[SRC_TX_OFLOW] = data_wr && tx_full;
        src_set[SRC_TX_THR]   = 32'(tx_free) >= 32'(tx_thr_q);
        src_set[SRC_DONE]     = evt_done;
        src_set[SRC_BUS_ERR]  = evt_bus_err;
        src_set[SRC_PROTO]    = evt_proto_err;
        src_set[SRC_DMA]      = evt_dma_done;
    end

    irq_collect #(.N(NUM_SRC)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .set_i(src_set),
        .clr_we(clr_we), .clr_i(reg_wdata[NUM_SRC-1:0]),
        .mask_we(mask_we), .mask_i(reg_wdata[NUM_SRC-1:0]),
        .raw_o(raw_q), .mask_o(mask_q), .pend_o(pend_q),
        .irq_o(irq)
    );

    // status word packing
    always_comb begin
        stat_word                 = '0;
        stat_word[0]              = tx_full;
        stat_word[1]              = tx_empty;
        stat_word[2]              = rx_empty;
        stat_word[3]              = rx_full;
        stat_word[8 +: FIELD_W]   = FIELD_W'(tx_free);
        stat_word[16 +: FIELD_W]  = FIELD_W'(rx_cnt);
    end

    // host read multiplexer
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_DATA: reg_rdata = rx_empty ? '0 : rx_head;
            OFS_THR:  begin
                reg_rdata[THR_W-1:0]  = tx_thr_q;
                reg_rdata[8 +: THR_W] = rx_thr_q;
            end
            OFS_MASK: reg_rdata[NUM_SRC-1:0] = mask_q;
            OFS_RAW:  reg_rdata[NUM_SRC-1:0] = raw_q;
            OFS_PEND: reg_rdata[NUM_SRC-1:0] = pend_q;
            OFS_STAT: reg_rdata = stat_word;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fifo_irq_unit_chk.sv
// Property checker for fifo_irq_unit, attached by bind below.
module fifo_irq_unit_chk #(
    parameter int DEPTH = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_rd,
    input logic [2:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        tx_pop,
    input logic        irq,
    input logic [7:0]  raw_q,
    input logic [7:0]  mask_q,
    input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
    input logic        tx_full,
    input logic        rx_empty
);
    logic       wr_data, rd_data, wr_clr;
    logic [7:0] keep;

    assign wr_data = reg_wr && (reg_addr == 3'd0);
    assign rd_data = reg_rd && (reg_addr == 3'd0);
    assign wr_clr  = reg_wr && (reg_addr == 3'd3);
    assign keep    = wr_clr ? (raw_q & ~reg_wdata[7:0]) : raw_q;

    // R6
    oflow_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && tx_full |=> raw_q[2]);

    // R6
    oflow_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data && tx_full && !tx_pop |=> $stable(tx_cnt));

    // R7
    uflow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && rx_empty |-> reg_rdata == 32'd0);

    // R7
    uflow_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data && rx_empty |=> raw_q[1]);

    // R10
    sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_q & $past(keep)) == $past(keep)));

    // R9
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q == 8'hFF |-> !irq);
endmodule

bind fifo_irq_unit fifo_irq_unit_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .irq(irq), .raw_q(raw_q), .mask_q(mask_q),
    .tx_cnt(tx_cnt), .tx_full(tx_full), .rx_empty(rx_empty)
);

// File: tb/tb_fifo_irq_unit.sv
// Self-checking bench: directed corners then seeded random traffic,
// compared each cycle against a behavioural model kept in the bench.
module tb_fifo_irq_unit;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, rx_data = 0;
    logic        tx_pop = 0, rx_push = 0;
    logic        evt_done = 0, evt_bus_err = 0, evt_proto_err = 0, evt_dma_done = 0;
    logic [31:0] reg_rdata, tx_data;
    logic        tx_avail, irq;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // model state
    logic [31:0] txq[$];
    logic [31:0] rxq[$];
    logic [7:0]  m_raw, m_mask;
    logic [4:0]  m_tthr, m_rthr;

    always #4 clk = ~clk;

    fifo_irq_unit #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_pop(tx_pop), .tx_data(tx_data), .tx_avail(tx_avail),
        .rx_push(rx_push), .rx_data(rx_data),
        .evt_done(evt_done), .evt_bus_err(evt_bus_err),
        .evt_proto_err(evt_proto_err), .evt_dma_done(evt_dma_done),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        logic [31:0] v = 0;
        case (a)
            3'd0: v = (rxq.size() == 0) ? 32'd0 : rxq[0];
            3'd1: begin v[4:0] = m_tthr; v[12:8] = m_rthr; end
            3'd2: v[7:0] = m_mask;
            3'd4: v[7:0] = m_raw;
            3'd5: v[7:0] = m_raw & ~m_mask;
            3'd6: begin
                v[0] = (txq.size() == DEPTH);
                v[1] = (txq.size() == 0);
                v[2] = (rxq.size() == 0);
                v[3] = (rxq.size() == DEPTH);
                v[12:8]  = 5'(DEPTH - txq.size());
                v[20:16] = 5'(rxq.size());
            end
            default: v = 0;
        endcase
        return v;
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0: return "R3";
            3'd1: return "R5";
            3'd2: return "R9";
            3'd4: return "R10";
            3'd5: return "R9";
            3'd6: return "R4";
            default: return "R4";
        endcase
    endfunction

    // apply current inputs for one cycle: check before the edge, update model after
    task automatic step();
        logic [7:0] set, clr;
        bit tx_full_p, tx_empty_p, rx_full_p, rx_empty_p;
        #2;
        chk("R9", {31'd0, irq}, {31'd0, |(m_raw & ~m_mask)});
        chk("R2", {31'd0, tx_avail}, {31'd0, txq.size() != 0});
        if (txq.size() != 0) chk("R2", tx_data, txq[0]);
        if (reg_rd) chk(tag_of(reg_addr), reg_rdata, exp_read(reg_addr));
        @(posedge clk);
        tx_full_p  = (txq.size() == DEPTH);
        tx_empty_p = (txq.size() == 0);
        rx_full_p  = (rxq.size() == DEPTH);
        rx_empty_p = (rxq.size() == 0);
        set = 0; clr = 0;
        set[0] = (rxq.size() >= int'(m_rthr));
        set[3] = ((DEPTH - txq.size()) >= int'(m_tthr));
        set[1] = reg_rd && reg_addr == 0 && rx_empty_p;
        set[2] = reg_wr && reg_addr == 0 && tx_full_p;
        set[4] = evt_done; set[5] = evt_bus_err;
        set[6] = evt_proto_err; set[7] = evt_dma_done;
        if (reg_wr && reg_addr == 3) clr = reg_wdata[7:0];
        if (tx_pop && !tx_empty_p) void'(txq.pop_front());
        if (reg_wr && reg_addr == 0 && !tx_full_p) txq.push_back(reg_wdata);
        if (reg_rd && reg_addr == 0 && !rx_empty_p) void'(rxq.pop_front());
        if (rx_push && !rx_full_p) rxq.push_back(rx_data);
        if (reg_wr && reg_addr == 1) begin m_tthr = reg_wdata[4:0]; m_rthr = reg_wdata[12:8]; end
        if (reg_wr && reg_addr == 2) m_mask = reg_wdata[7:0];
        m_raw = (m_raw & ~clr) | set;
        @(negedge clk);
        reg_wr = 0; reg_rd = 0; tx_pop = 0; rx_push = 0;
        evt_done = 0; evt_bus_err = 0; evt_proto_err = 0; evt_dma_done = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d; step();
    endtask

    task automatic rd(input logic [2:0] a);
        reg_rd = 1; reg_addr = a; step();
    endtask

    initial begin
        #200000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        done = 1;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        m_raw = 0; m_mask = 8'hFF; m_tthr = 0; m_rthr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state, read before the first edge updates anything
        #2;
        reg_addr = 3'd2; #1; chk("R1", reg_rdata, 32'h0000_00FF);
        reg_addr = 3'd4; #1; chk("R1", reg_rdata, 32'd0);
        reg_addr = 3'd6; #1; chk("R1", reg_rdata, 32'h0000_1006);
        reg_addr = 3'd1; #1; chk("R1", reg_rdata, 32'd0);
        @(negedge clk);
        m_raw = 8'h09; // first edge after release latched both threshold sources
        // R5: raise thresholds out of reach, then clear everything
        wr(3'd1, 32'h0000_1F1F);
        wr(3'd3, 32'hFF);
        rd(3'd4);
        // R10: event and clear of the same bit together, event wins
        evt_done = 1; wr(3'd3, 32'h10);
        rd(3'd4);
        // R10: clear with zeros has no effect
        wr(3'd3, 32'h00);
        rd(3'd4);
        wr(3'd3, 32'h10);
        rd(3'd4);
        // R8: each event source
        evt_bus_err = 1; step();
        evt_proto_err = 1; evt_dma_done = 1; step();
        rd(3'd4);
        // R9: unmask and watch irq / pending
        wr(3'd2, 32'h0000_00E0);
        rd(3'd5);
        // R6: overfill transmit FIFO
        for (int i = 0; i < DEPTH + 2; i++) wr(3'd0, 32'hA000_0000 + i);
        rd(3'd6); rd(3'd4);
        // R2: drain a few
        for (int i = 0; i < 3; i++) begin tx_pop = 1; step(); end
        rd(3'd6);
        // R7: read empty receive FIFO
        rd(3'd0); rd(3'd4);
        // R3: fill receive to full plus one, read back
        for (int i = 0; i < DEPTH + 1; i++) begin rx_push = 1; rx_data = 32'hB000_0000 + i; step(); end
        rd(3'd6);
        for (int i = 0; i < 4; i++) rd(3'd0);
        // R5: thresholds now reachable
        wr(3'd1, 32'h0000_0804);
        wr(3'd3, 32'hFF);
        rd(3'd4);
        // random phase
        for (int n = 0; n < 4000 && !done; n++) begin
            int sel = int'($urandom_range(0, 9));
            tx_pop  = ($urandom_range(0, 3) == 0);
            rx_push = ($urandom_range(0, 2) == 0);
            rx_data = $urandom;
            evt_done      = ($urandom_range(0, 15) == 0);
            evt_bus_err   = ($urandom_range(0, 31) == 0);
            evt_proto_err = ($urandom_range(0, 31) == 0);
            evt_dma_done  = ($urandom_range(0, 15) == 0);
            reg_addr = 3'($urandom_range(0, 7));
            reg_wdata = $urandom;
            if (sel < 3) begin reg_wr = 1; reg_addr = 3'd0; end
            else if (sel < 6) begin reg_rd = 1; end
            else if (sel == 6) begin reg_wr = 1; reg_addr = 3'($urandom_range(1, 3)); end
            else if (sel == 7) begin reg_rd = 1; reg_addr = 3'd0; end
            step();
        end
        done = 1;
    end

    initial begin
        wait (done);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule